// File: doc/BRIEF.md
# Bus-Attached Control Register and GPIO Port Block

This peripheral sits on a simple register bus and holds a bank of 16-bit control registers together with a 16-line general-purpose port. Software writes mode, card-detect, power, card-control and three interrupt storage registers (plain storage only, no interrupt is ever raised), reads a fixed status word, and drives the port through a direction register and a level register that is reachable at two aliased offsets.

Port outputs show the level bit gated by the direction bit. They are refreshed only when software writes the direction or the level. Within such a refresh, only lines whose gated value differs are touched. External input lines overwrite level bits when they change, but they do not move the outputs until the next direction or level write. A power write with its trigger bit set also forces two more bits high in the stored value.

Access is single-cycle. A write lands on the clock edge where the write enable is high. Read data is registered and appears one clock after the read enable.

Top module: `gpio_ctl_regs`

## Requirements
- R1: After reset the status register reads 0x0002, and every other register reads 0. This covers the direction and level registers. `gpio_out` is 0.
- R2: Only `addr[5:0]` is decoded, so the map repeats every 0x40 bytes. The offsets are:
  - mode 0x00
  - card-detect 0x04
  - status 0x08
  - power 0x0C
  - card-control 0x10
  - raw-interrupt 0x14
  - interrupt-mask 0x18
  - interrupt-status 0x1C
  - direction 0x20
  - level 0x24
  - level alias 0x28
- R3: The write data is cut to bits 15:0 before it is stored. A read returns the stored 16-bit value in `rd_data`.
- R4: A write to power with data bit 7 set stores the 16-bit data OR 0x8040. Without bit 7 it stores the data unchanged.
- R5: A write to 0x24 or to 0x28 stores the write data ANDed with the current direction. A read at either offset returns the level register.
- R6: On the edge of a direction or level write, `gpio_out` becomes the new level AND the new direction.
- R7: Outside direction or level writes, `gpio_out` holds its value. This includes cycles where input lines change.
- R8: A bit of `gpio_in` that differs from its value sampled at the previous edge copies its new value into the matching level bit at that edge. This wins over a level write in the same cycle.
- R9: The status register is read-only, and a write to 0x08 does not change it.
- R10: A read at an unmapped offset returns 0. A write there changes no register.
- R11: `rd_data` is valid one clock after `rd_en`, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 12 | Byte address; the low 6 bits are decoded |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; the upper 16 bits are discarded |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| gpio_in | input | 16 | External input lines |
| gpio_out | output | 16 | Port outputs, level gated by direction |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high with an unknown address, and that `gpio_in` is steady around the clock edge. The level-masking property also assumes that no input line toggles in the cycle of the level write it checks. It does not fire in cycles where an input changes.

The stimulus drives every input at the falling edge, which keeps them clear of the rising edge. Random input changes are kept out of write cycles. A single directed cycle combines a level write with an input toggle, to show that the input wins.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int REG_W  = 16;
    localparam int OFF_W  = 6;
    localparam int N_CFG  = 7;

    localparam logic [OFF_W-1:0] OFF_MODE = 6'h00;
    localparam logic [OFF_W-1:0] OFF_CDET = 6'h04;
    localparam logic [OFF_W-1:0] OFF_STAT = 6'h08;
    localparam logic [OFF_W-1:0] OFF_PWR  = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_CCTL = 6'h10;
    localparam logic [OFF_W-1:0] OFF_IRAW = 6'h14;
    localparam logic [OFF_W-1:0] OFF_IMSK = 6'h18;
    localparam logic [OFF_W-1:0] OFF_ISTS = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_DIR  = 6'h20;
    localparam logic [OFF_W-1:0] OFF_LVLW = 6'h24;
    localparam logic [OFF_W-1:0] OFF_LVLR = 6'h28;

    localparam logic [REG_W-1:0] STATUS_VALUE = 16'h0002;
    localparam logic [REG_W-1:0] PWR_SET_MASK = 16'h8040;
    localparam int               PWR_TRIG_BIT = 7;
    localparam int               PWR_IDX      = 2;

    // storage slot index -> bus offset
    function automatic logic [OFF_W-1:0] cfg_offset(input int idx);
        case (idx)
            0:       return OFF_MODE;
            1:       return OFF_CDET;
            2:       return OFF_PWR;
            3:       return OFF_CCTL;
            4:       return OFF_IRAW;
            5:       return OFF_IMSK;
            default: return OFF_ISTS;
        endcase
    endfunction

    function automatic logic is_level_off(input logic [OFF_W-1:0] off);
        return (off == OFF_LVLW) || (off == OFF_LVLR);
    endfunction

    function automatic logic is_mapped(input logic [OFF_W-1:0] off);
        return (off[1:0] == 2'b00) && (off <= OFF_LVLR);
    endfunction

endpackage

// File: rtl/gpio_ctl_cfg_bank.sv
module gpio_ctl_cfg_bank
    import gpio_ctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [OFF_W-1:0]            off,
    input  logic [REG_W-1:0]            wd,
    output logic [N_CFG-1:0][REG_W-1:0] cfg_q
);

    genvar i;
    generate
        for (i = 0; i < N_CFG; i++) begin : g_slot
            localparam logic [OFF_W-1:0] SLOT_OFF = cfg_offset(i);
            logic [REG_W-1:0] next_val;
            logic             hit;

            assign hit = wr_en && (off == SLOT_OFF);

            if (i == PWR_IDX) begin : g_pwr
                always_comb begin
                    next_val = wd;
                    if (wd[PWR_TRIG_BIT]) begin
                        next_val = wd | PWR_SET_MASK;
                    end
                end
            end else begin : g_plain
                assign next_val = wd;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[i] <= '0;
                end else if (hit) begin
                    cfg_q[i] <= next_val;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_ctl_port.sv
module gpio_ctl_port
    import gpio_ctl_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_we,
    input  logic               lvl_we,
    input  logic [N_LINES-1:0] wd,
    input  logic [N_LINES-1:0] gpio_in,
    output logic [N_LINES-1:0] dir_q,
    output logic [N_LINES-1:0] lvl_q,
    output logic [N_LINES-1:0] in_chg,
    output logic [N_LINES-1:0] gpio_out
);

    logic [N_LINES-1:0] in_prev_q;
    logic [N_LINES-1:0] dir_d;
    logic [N_LINES-1:0] lvl_w;
    logic [N_LINES-1:0] lvl_d;
    logic [N_LINES-1:0] eff;
    logic               reeval;

    assign in_chg = gpio_in ^ in_prev_q;

    always_comb begin
        dir_d = dir_we ? wd : dir_q;
        lvl_w = lvl_we ? (wd & dir_q) : lvl_q;
        lvl_d = (lvl_w & ~in_chg) | (gpio_in & in_chg);
        eff   = lvl_d & dir_d;
    end

    assign reeval = dir_we || lvl_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            lvl_q     <= '0;
            in_prev_q <= '0;
        end else begin
            dir_q     <= dir_d;
            lvl_q     <= lvl_d;
            in_prev_q <= gpio_in;
        end
    end

    // per-line output latch, touched only when its gated value differs
    genvar b;
    generate
        for (b = 0; b < N_LINES; b++) begin : g_line
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    gpio_out[b] <= 1'b0;
                end else if (reeval && (eff[b] != gpio_out[b])) begin
                    gpio_out[b] <= eff[b];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_ctl_readback.sv
module gpio_ctl_readback
    import gpio_ctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [OFF_W-1:0]            off,
    input  logic [N_CFG-1:0][REG_W-1:0] cfg_q,
    input  logic [REG_W-1:0]            dir_q,
    input  logic [REG_W-1:0]            lvl_q,
    output logic [REG_W-1:0]            rd_data
);

    logic [REG_W-1:0] sel;

    always_comb begin
        sel = '0;
        case (off)
            OFF_STAT:           sel = STATUS_VALUE;
            OFF_DIR:            sel = dir_q;
            OFF_LVLW, OFF_LVLR: sel = lvl_q;
            default: begin
                for (int k = 0; k < N_CFG; k++) begin
                    if (off == cfg_offset(k)) begin
                        sel = cfg_q[k];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel;
        end
    end

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gpio_ctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int N_GPIO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic [N_GPIO-1:0] gpio_in,
    output logic [N_GPIO-1:0] gpio_out
);

    logic [OFF_W-1:0]            off;
    logic [REG_W-1:0]            wd;
    logic [N_CFG-1:0][REG_W-1:0] cfg_q;
    logic [N_GPIO-1:0]           dir_q;
    logic [N_GPIO-1:0]           lvl_q;
    logic [N_GPIO-1:0]           in_chg;
    logic [REG_W-1:0]            pwr_q;
    logic                        dir_we;
    logic                        lvl_we;

    assign off    = addr[OFF_W-1:0];
    assign wd     = wr_data[REG_W-1:0];
    assign dir_we = wr_en && (off == OFF_DIR);
    assign lvl_we = wr_en && is_level_off(off);
    assign pwr_q  = cfg_q[PWR_IDX];

    gpio_ctl_cfg_bank u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .off   (off),
        .wd    (wd),
        .cfg_q (cfg_q)
    );

    gpio_ctl_port #(.N_LINES(N_GPIO)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_we   (dir_we),
        .lvl_we   (lvl_we),
        .wd       (wd[N_GPIO-1:0]),
        .gpio_in  (gpio_in),
        .dir_q    (dir_q),
        .lvl_q    (lvl_q),
        .in_chg   (in_chg),
        .gpio_out (gpio_out)
    );

    gpio_ctl_readback u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .off     (off),
        .cfg_q   (cfg_q),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/gpio_ctl_regs_chk.sv
module gpio_ctl_regs_chk
    import gpio_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [OFF_W-1:0] off,
    input logic [31:0]      wr_data,
    input logic [15:0]      rd_data,
    input logic [15:0]      gpio_out,
    input logic [15:0]      dir_q,
    input logic [15:0]      lvl_q,
    input logic [15:0]      in_chg,
    input logic [15:0]      pwr_q
);

    logic port_write;
    assign port_write = wr_en && ((off == OFF_DIR) || is_level_off(off));

    a_r4_power_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_PWR && wr_data[PWR_TRIG_BIT]) |=> (pwr_q[15] && pwr_q[6]));

    a_r5_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_level_off(off) && in_chg == 16'h0)
            |=> (lvl_q == ($past(wr_data[15:0]) & $past(dir_q))));

    a_r6_out_within_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out & ~dir_q) == 16'h0);

    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !port_write |=> $stable(gpio_out));

    a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off == OFF_STAT) |=> (rd_data == STATUS_VALUE));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_mapped(off)) |=> (rd_data == 16'h0));

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind gpio_ctl_regs gpio_ctl_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .off      (off),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .gpio_out (gpio_out),
    .dir_q    (dir_q),
    .lvl_q    (lvl_q),
    .in_chg   (in_chg),
    .pwr_q    (pwr_q)
);

// File: tb/gpio_ctl_regs_test.sv
module gpio_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [15:0] m_cfg [0:6];
    logic [15:0] m_dir, m_lvl, m_out, m_inp;

    always #2 clk = ~clk;

    gpio_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .gpio_in(gpio_in), .gpio_out(gpio_out)
    );

    function automatic int slot_of(input logic [5:0] o);
        case (o)
            6'h00: return 0;
            6'h04: return 1;
            6'h0C: return 2;
            6'h10: return 3;
            6'h14: return 4;
            6'h18: return 5;
            6'h1C: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [11:0] a);
        logic [5:0] o;
        o = a[5:0];
        if (o == 6'h08) return 16'h0002;
        if (o == 6'h20) return m_dir;
        if (o == 6'h24 || o == 6'h28) return m_lvl;
        if (slot_of(o) >= 0) return m_cfg[slot_of(o)];
        return 16'h0000;
    endfunction

    function automatic logic [15:0] exp_power(input logic [15:0] v);
        return v[7] ? (v | 16'h8040) : v;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: optional write plus a new input value, model updated after the edge
    task automatic bus_cycle(input logic do_wr, input logic [11:0] a,
                             input logic [31:0] d, input logic [15:0] inv);
        logic [5:0]  o;
        logic [15:0] chg;
        logic        port_wr;
        @(negedge clk);
        addr = a; wr_data = d; wr_en = do_wr; gpio_in = inv;
        @(negedge clk);
        wr_en = 1'b0;
        o = a[5:0];
        port_wr = 1'b0;
        if (do_wr) begin
            if (slot_of(o) == 2) m_cfg[2] = exp_power(d[15:0]);
            else if (slot_of(o) >= 0) m_cfg[slot_of(o)] = d[15:0];
            else if (o == 6'h20) begin m_dir = d[15:0]; port_wr = 1'b1; end
            else if (o == 6'h24 || o == 6'h28) begin m_lvl = d[15:0] & m_dir; port_wr = 1'b1; end
        end
        chg   = inv ^ m_inp;
        m_lvl = (m_lvl & ~chg) | (inv & chg);
        m_inp = inv;
        if (port_wr) m_out = m_lvl & m_dir;
        chk(port_wr ? "R6 gpio_out after port write" : "R7 gpio_out hold", gpio_out, m_out);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_cycle(1'b1, a, d, gpio_in);
    endtask

    task automatic set_in(input logic [15:0] v);
        bus_cycle(1'b0, 12'h0, 32'h0, v);
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, exp_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] hold;
        void'($urandom(32'd4242));
        for (int i = 0; i < 7; i++) m_cfg[i] = '0;
        m_dir = '0; m_lvl = '0; m_out = '0; m_inp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk("R1 gpio_out reset", gpio_out, 16'h0);
        for (int o = 0; o <= 6'h28; o += 4) rd("R1 reset register", 12'(o));

        // R2 alias across the 0x40 window
        wr(12'h140, 32'h0000_5A5A);
        rd("R2 alias read of mode", 12'h000);
        rd("R2 alias read high window", 12'h7C0);

        // R3 truncation
        wr(12'h010, 32'hABCD_1234);
        rd("R3 truncated card-control", 12'h010);
        chk("R3 literal", rd_data, 16'h1234);

        // R4 power trigger
        wr(12'h00C, 32'h0000_0080);
        rd("R4 power with trigger", 12'h00C);
        chk("R4 power literal", rd_data, 16'h80C0);
        wr(12'h00C, 32'h0000_0101);
        rd("R4 power without trigger", 12'h00C);

        // R9 status read-only
        wr(12'h008, 32'h0000_FFFF);
        rd("R9 status after write", 12'h008);

        // R10 unmapped
        wr(12'h02C, 32'h0000_FFFF);
        wr(12'h001, 32'h0000_FFFF);
        rd("R10 unmapped read 0x2C", 12'h02C);
        rd("R10 unmapped read 0x3C", 12'h03C);
        rd("R10 mode untouched", 12'h000);
        rd("R10 card-detect untouched", 12'h004);

        // R5 level masking through the alias
        wr(12'h020, 32'h0000_00FF);
        wr(12'h028, 32'h0000_FFFF);
        rd("R5 level via 0x24", 12'h024);
        chk("R5 level literal", rd_data, 16'h00FF);
        chk("R6 gpio_out literal", gpio_out, 16'h00FF);

        // R7/R8 input change moves level but not outputs
        set_in(16'h0F00);
        rd("R8 level after input", 12'h028);
        chk("R8 level literal", rd_data, 16'h0FFF);
        chk("R7 outputs unchanged", gpio_out, 16'h00FF);
        wr(12'h020, 32'h0000_FFFF);
        chk("R6 outputs after dir write", gpio_out, 16'h0FFF);

        // R8 input wins over a simultaneous level write
        bus_cycle(1'b1, 12'h024, 32'h0000_0000, 16'h0F01);
        rd("R8 input wins over write", 12'h024);
        chk("R8 win literal", rd_data, 16'h0001);

        // R11 hold while rd_en low
        rd("R11 read", 12'h020);
        hold = rd_data;
        @(negedge clk); addr = 12'h000;
        @(negedge clk);
        chk("R11 rd_data hold", rd_data, hold);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 3);
            a  = 12'($urandom);
            if (($urandom % 4) != 0) a[5:0] = 6'(($urandom % 12) * 4);
            if (op == 0) wr(a, $urandom);
            else if (op == 1) rd("R2 random read", a);
            else set_in(16'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule